// File: doc/BRIEF.md
# Load Clock Divider with Odd-Modulus Half-Cycle Correction

This block derives a slower load clock from a fast pixel clock. A 5-bit frequency-select address picks one of 32 entries in a built-in constant table. Each entry holds either a divide modulus from the fixed set 3, 4, 5, 6, 8 and 10, or a mute flag that holds the load clock low. The load clock keeps an exact 50% duty cycle for every modulus. For the odd moduli 3 and 5, a falling-edge copy of the high pulse stretches the high phase by half an input cycle.

A three-state machine sets the timing. ST_MUTE holds the output low. ST_HIGH and ST_LOW each count out their half of one output period. The transitions are:

- ST_MUTE→ST_HIGH when the table entry is not muted.
- ST_HIGH→ST_LOW when the high count ends.
- ST_LOW→ST_HIGH at the period boundary when the entry is not muted.
- ST_LOW→ST_MUTE at the period boundary when the entry is muted.
- ST_MUTE→ST_MUTE while the entry stays muted.

Reset puts the machine in ST_MUTE. The table is read only in ST_MUTE and at the period boundary, so a change of address never cuts a pulse short.

Top module: `ldclk_div`

## Requirements
- R1: The table maps address a in 0..27 to modulus code a[2:0]. Code 0 gives 3, code 1 gives 4, code 2 gives 5, code 3 gives 6, code 4 gives 8 and code 5 gives 10. Codes 6 and 7 default to 4.
- R2: The divide modulus is always one of 3, 4, 5, 6, 8 or 10. `mod_o` reports the modulus in use as a 4-bit binary value, or 0 when muted.
- R3: For a modulus N, the load clock is high for exactly N half-cycles of the input clock and low for exactly N half-cycles.
- R4: Addresses 28 to 31 are muted. Once such an entry is in force, `ld_clk_o` stays low and `mod_o` reads 0.
- R5: A new address takes effect only at an output period boundary. `mod_o` changes only together with a rising edge of `ld_clk_o`. Every high or low phase has the full length of either the old or the new modulus.
- R6: While `rst_ni` is low, `ld_clk_o` and `mod_o` are 0. On the first rising clock edge after release, with an unmuted address, `ld_clk_o` rises and a full-length period begins.
- R7: In the muted state, `ld_clk_o` rises on the first rising clock edge at which the address selects an unmuted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast pixel clock; both edges are used |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 5 | Frequency-select address into the modulus table |
| ld_clk_o | output | 1 | Divided load clock, 50% duty |
| mod_o | output | 4 | Modulus in use, 0 when muted |

## Verification
The bench times every high and low phase in half-cycles of the input clock. An odd-modulus design that lacked the falling-edge stretch would show runs of N-1 and N+1 instead of N and N. It switches the address in mid-period between odd and even moduli. A design that reloaded at once would produce a runt phase whose length matches neither modulus. It also checks the exact cycle of the first rising edge after reset and after leaving the muted state. An off-by-one in the machine would shift that edge or shorten the first period. Finally, it checks that the muted addresses force the output low and report a modulus of zero.

// File: rtl/ldclk_pkg.sv
package ldclk_pkg;

    localparam int ADDR_W = 5;
    localparam int CODE_W = 3;
    localparam int MOD_W  = 4;

    typedef struct packed {
        logic              mute;
        logic [CODE_W-1:0] code;
    } ldclk_entry_t;

    typedef enum logic [1:0] {
        ST_MUTE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } ldclk_state_t;

    function automatic logic [MOD_W-1:0] div_of_code(input logic [CODE_W-1:0] c);
        case (c)
            3'd0:    return 4'd3;
            3'd1:    return 4'd4;
            3'd2:    return 4'd5;
            3'd3:    return 4'd6;
            3'd4:    return 4'd8;
            3'd5:    return 4'd10;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/ldclk_table.sv
module ldclk_table
    import ldclk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output ldclk_entry_t      entry_o
);

    always_comb begin
        case (addr_i)
            5'd0:    entry_o = '{mute: 1'b0, code: 3'd0};
            5'd1:    entry_o = '{mute: 1'b0, code: 3'd1};
            5'd2:    entry_o = '{mute: 1'b0, code: 3'd2};
            5'd3:    entry_o = '{mute: 1'b0, code: 3'd3};
            5'd4:    entry_o = '{mute: 1'b0, code: 3'd4};
            5'd5:    entry_o = '{mute: 1'b0, code: 3'd5};
            5'd6:    entry_o = '{mute: 1'b0, code: 3'd6};
            5'd7:    entry_o = '{mute: 1'b0, code: 3'd7};
            5'd8:    entry_o = '{mute: 1'b0, code: 3'd0};
            5'd9:    entry_o = '{mute: 1'b0, code: 3'd1};
            5'd10:   entry_o = '{mute: 1'b0, code: 3'd2};
            5'd11:   entry_o = '{mute: 1'b0, code: 3'd3};
            5'd12:   entry_o = '{mute: 1'b0, code: 3'd4};
            5'd13:   entry_o = '{mute: 1'b0, code: 3'd5};
            5'd14:   entry_o = '{mute: 1'b0, code: 3'd6};
            5'd15:   entry_o = '{mute: 1'b0, code: 3'd7};
            5'd16:   entry_o = '{mute: 1'b0, code: 3'd0};
            5'd17:   entry_o = '{mute: 1'b0, code: 3'd1};
            5'd18:   entry_o = '{mute: 1'b0, code: 3'd2};
            5'd19:   entry_o = '{mute: 1'b0, code: 3'd3};
            5'd20:   entry_o = '{mute: 1'b0, code: 3'd4};
            5'd21:   entry_o = '{mute: 1'b0, code: 3'd5};
            5'd22:   entry_o = '{mute: 1'b0, code: 3'd6};
            5'd23:   entry_o = '{mute: 1'b0, code: 3'd7};
            5'd24:   entry_o = '{mute: 1'b0, code: 3'd0};
            5'd25:   entry_o = '{mute: 1'b0, code: 3'd1};
            5'd26:   entry_o = '{mute: 1'b0, code: 3'd2};
            5'd27:   entry_o = '{mute: 1'b0, code: 3'd3};
            5'd28:   entry_o = '{mute: 1'b1, code: 3'd4};
            5'd29:   entry_o = '{mute: 1'b1, code: 3'd5};
            5'd30:   entry_o = '{mute: 1'b1, code: 3'd6};
            5'd31:   entry_o = '{mute: 1'b1, code: 3'd7};
            default: entry_o = '{mute: 1'b1, code: 3'd1};
        endcase
    end

endmodule

// File: rtl/ldclk_fsm.sv
module ldclk_fsm
    import ldclk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  ldclk_entry_t     entry_i,
    output logic             rise_pulse_o,
    output logic             odd_o,
    output logic [MOD_W-1:0] mod_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ldclk_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_q, hi_d;
    logic [CNT_W-1:0] lo_q, lo_d;
    logic [MOD_W-1:0] mod_q, mod_d;
    logic             odd_q, odd_d;
    logic             pulse_q;
    logic             load;
    logic [MOD_W-1:0] div_new;

    assign div_new = div_of_code(entry_i.code);

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        hi_d    = hi_q;
        lo_d    = lo_q;
        mod_d   = mod_q;
        odd_d   = odd_q;
        load    = 1'b0;
        unique case (state_q)
            ST_MUTE: begin
                cnt_d = '0;
                if (!entry_i.mute) begin
                    load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (cnt_q == hi_q - ONE) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
            end
            ST_LOW: begin
                if (cnt_q == lo_q - ONE) begin
                    if (entry_i.mute) begin
                        state_d = ST_MUTE;
                        cnt_d   = '0;
                        mod_d   = '0;
                        odd_d   = 1'b0;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_MUTE;
                cnt_d   = '0;
                mod_d   = '0;
                odd_d   = 1'b0;
            end
        endcase
        if (load) begin
            state_d = ST_HIGH;
            cnt_d   = '0;
            mod_d   = div_new;
            odd_d   = div_new[0];
            hi_d    = CNT_W'(div_new >> 1);
            lo_d    = CNT_W'(div_new - (div_new >> 1));
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_MUTE;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
            mod_q   <= '0;
            odd_q   <= 1'b0;
        end else begin
            pulse_q <= (state_d == ST_HIGH);
            mod_q   <= mod_d;
            odd_q   <= odd_d;
        end
    end

    assign rise_pulse_o = pulse_q;
    assign odd_o        = odd_q;
    assign mod_o        = mod_q;

endmodule

// File: rtl/ldclk_halfret.sv
module ldclk_halfret (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    input  logic enable_i,
    output logic pulse_o
);

    logic late_q;

    // half-cycle delayed copy, only passed on for odd moduli
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            late_q <= 1'b0;
        end else begin
            late_q <= pulse_i & enable_i;
        end
    end

    assign pulse_o = late_q;

endmodule

// File: rtl/ldclk_div.sv
module ldclk_div
    import ldclk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] fsel_i,
    output logic              ld_clk_o,
    output logic [MOD_W-1:0]  mod_o
);

    ldclk_entry_t entry;
    logic         pulse_r;
    logic         pulse_f;
    logic         odd;

    ldclk_table u_table (
        .addr_i  (fsel_i),
        .entry_o (entry)
    );

    ldclk_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .entry_i      (entry),
        .rise_pulse_o (pulse_r),
        .odd_o        (odd),
        .mod_o        (mod_o)
    );

    ldclk_halfret u_halfret (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pulse_i  (pulse_r),
        .enable_i (odd),
        .pulse_o  (pulse_f)
    );

    assign ld_clk_o = pulse_r | pulse_f;

endmodule

// File: rtl/ldclk_div_chk.sv
module ldclk_div_chk #(
    parameter int MOD_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ld_clk_o,
    input logic [MOD_W-1:0] mod_o
);

    localparam int MAX_HI = 5;

    logic [3:0] hi_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run_q <= '0;
        end else if (!ld_clk_o) begin
            hi_run_q <= '0;
        end else if (hi_run_q != 4'hF) begin
            hi_run_q <= hi_run_q + 4'd1;
        end
    end

    AST_MOD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mod_o == 0 || mod_o == 3 || mod_o == 4 || mod_o == 5 ||
         mod_o == 6 || mod_o == 8 || mod_o == 10)); // R2

    AST_MUTE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mod_o == 0) |-> !ld_clk_o); // R4

    AST_SWITCH_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mod_o != $past(mod_o) && mod_o != 0) |-> (ld_clk_o && !$past(ld_clk_o))); // R5

    AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_run_q <= MAX_HI); // R3

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> (!ld_clk_o && mod_o == 0)); // R6

endmodule

bind ldclk_div ldclk_div_chk #(.MOD_W(4)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_clk_o (ld_clk_o),
    .mod_o    (mod_o)
);

// File: tb/ldclk_div_tb_top.sv
module ldclk_div_tb_top;

    logic       clk;
    logic       rst_n;
    logic [4:0] fsel;
    logic       ld;
    logic [3:0] modv;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    ldclk_div dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .fsel_i   (fsel),
        .ld_clk_o (ld),
        .mod_o    (modv)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    localparam int NV = 10;
    localparam logic [4:0] V_ADDR [NV] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4,
                                          5'd5, 5'd6, 5'd15, 5'd29, 5'd10};
    localparam int V_DIV [NV] = '{3, 4, 5, 6, 8, 10, 4, 4, 0, 5};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // measures one constant-level run in half-cycle samples
    task automatic run(output int len, output logic lvl);
        lvl = ld;
        len = 0;
        while (ld == lvl && len < 400) begin
            len++;
            #5;
        end
    endtask

    task automatic align();
        @(posedge clk);
        #2;
    endtask

    task automatic switch_test(input logic [4:0] a_old, input int n_old,
                               input logic [4:0] a_new, input int n_new);
        int   l;
        logic v;
        fsel = a_old;
        #300;
        run(l, v);
        #15;
        fsel = a_new;
        run(l, v);
        for (int k = 0; k < 8; k++) begin
            run(l, v);
            chk(l == n_old || l == n_new, "R5 run length after switch", l, n_new);
        end
        chk(modv == 4'(n_new), "R5 modulus after switch", modv, n_new);
    endtask

    initial begin
        int   l;
        logic v;
        int   bad;
        rst_n = 1'b1;
        fsel  = 5'd1;
        #1 rst_n = 1'b0;
        #20;
        chk(ld == 1'b0, "R6 load clock low in reset", ld, 0);
        chk(modv == 4'd0, "R6 modulus zero in reset", modv, 0);
        align();
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            fsel = V_ADDR[i];
            #600;
            if (V_DIV[i] == 0) begin
                bad = 0;
                for (int s = 0; s < 80; s++) begin
                    if (ld) bad++;
                    #5;
                end
                chk(bad == 0, "R4 muted address holds low", bad, 0);
                chk(modv == 4'd0, "R4 muted modulus reads zero", modv, 0);
            end else begin
                chk(modv == 4'(V_DIV[i]), "R1 R2 modulus from table", modv, V_DIV[i]);
                run(l, v);
                run(l, v);
                chk(l == V_DIV[i], "R3 phase length", l, V_DIV[i]);
                run(l, v);
                chk(l == V_DIV[i], "R3 phase length", l, V_DIV[i]);
            end
        end

        // switches in mid-period: R5
        switch_test(5'd2, 5, 5'd5, 10);
        switch_test(5'd5, 10, 5'd0, 3);
        switch_test(5'd3, 6, 5'd18, 5);

        // leaving the muted state: R7
        fsel = 5'd30;
        #300;
        chk(modv == 4'd0, "R7 muted before exit", modv, 0);
        align();
        fsel = 5'd3;
        #5;
        chk(ld == 1'b0, "R7 low before first edge", ld, 0);
        #5;
        chk(ld == 1'b1, "R7 rises on first edge", ld, 1);
        chk(modv == 4'd6, "R7 modulus on exit", modv, 6);

        // reset in mid-run, then first period: R6
        #40;
        rst_n = 1'b0;
        #3;
        chk(ld == 1'b0 && modv == 4'd0, "R6 async reset clears outputs", ld, 0);
        fsel = 5'd4;
        #30;
        align();
        rst_n = 1'b1;
        #5;
        chk(ld == 1'b0, "R6 low before first edge", ld, 0);
        #5;
        chk(ld == 1'b1, "R6 rises on first edge", ld, 1);
        chk(modv == 4'd8, "R6 modulus after reset", modv, 8);
        run(l, v);
        chk(l == 8, "R6 first high phase full length", l, 8);
        run(l, v);
        chk(l == 8, "R6 first low phase full length", l, 8);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule